// File: doc/BRIEF.md
# Shared-Buffer Pointer-Queue Packet Switch

This block is an output-queued packet switch with `NPORT` inputs and `NPORT` outputs that share one packet store. The data path and the control path are kept apart. A whole fixed-size packet (`PKT_WORDS` words of `WORD_W` bits) is written once into a free store slot. Only the short slot pointer travels through a small per-output pointer FIFO. When an output hands a packet over, it reads the slot named by its FIFO head. The slot goes back to the free pool once every destination has taken its copy.

Each input keeps one slot address that the free pool hands it before any packet arrives. An offered packet carries a destination bit mask. Setting more than one bit makes it a multicast: it occupies a single slot, and a pointer to that slot goes into each named output FIFO. A per-slot reference count tracks the copies still pending. The store has one write port, so at most one packet is accepted per cycle, and a round-robin arbiter picks among the inputs that could be stored.

Inputs use valid/ready. A sender keeps `in_valid` and its packet steady while it waits for `in_ready`. When `in_bp` is high, the packet cannot be stored as things stand. The sender may then keep offering it, swap in another packet, or withdraw it, and nothing inside the switch has changed. Outputs use valid/ready too: `out_data` stays steady while `out_valid` is high and `out_ready` is low.

Top module: `ptrq_switch`

## Requirements
- R1: After reset no output is valid and no input holds an address. Each cycle the pool hands one free slot to the lowest-numbered input holding none, and the lowest-numbered free slot is given. An input that was accepted holds no address in the following cycle.
- R2: An input is eligible when all of these hold: `in_valid` is high, the input holds an address, its destination mask is nonzero, and every output named in the mask has fewer than `QDEPTH` queued pointers. At most one input sees `in_ready` high in a cycle, and only an eligible input can see it.
- R3: Among eligible inputs, the first one found is accepted. The search starts at the input after the one last accepted (input 0 after reset) and counts upward with wrap-around.
- R4: `in_bp[i]` is high exactly when `in_valid[i]` is high and input i is not eligible. This covers three cases: no address held, a destination FIFO full, or a zero mask. A refused offer changes no queue and no slot.
- R5: The mask layout is fixed: bit `i*NPORT+o` of `in_dest` sends input i's packet to output o, and `in_data[i*PKT_W +: PKT_W]` carries it. An accepted packet is appended to each named output. `out_valid[o]` is high while that output has queued packets. `out_data` shows the oldest one, and packets come out in acceptance order. A transfer happens on `out_valid & out_ready`.
- R6: A multicast packet is delivered once on each output in its mask, with identical content, from a single slot.
- R7: With all outputs stalled, at most `SLOTS` packets can be accepted in total, counting addresses already held by inputs. After traffic drains, all `SLOTS` slots can be filled again, so no slot leaks.
- R8: A slot whose last pending copy leaves at a clock edge is free in the next cycle, so it may be handed to an input then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT | Per-input packet offered |
| in_dest | input | NPORT*NPORT | Destination masks, NPORT bits per input |
| in_data | input | NPORT*PKT_W | Packet contents, PKT_W bits per input |
| in_ready | output | NPORT | Packet accepted this cycle (one-hot or zero) |
| in_bp | output | NPORT | Offered packet cannot be stored now |
| out_valid | output | NPORT | Output has a packet to deliver |
| out_ready | input | NPORT | Output sink takes the packet |
| out_data | output | NPORT*PKT_W | Packet contents, PKT_W bits per output |

## Verification
The bench first drives every input at one output with the outputs stalled, so a FIFO fills. A switch that let a full queue accept a pointer would drop or overwrite entries, and the deliveries would go missing or repeat. A broadcast packet is followed through all outputs. A reference count that is released too early would hand its slot to a new packet, and a later output would then show foreign data. The bench also fills the store to capacity twice, with a drain in between. An address given out twice, or a slot never returned, shows up as corrupted data, an acceptance count other than `SLOTS`, or back-pressure where the model expects none. Long random runs with random output stalls and zero masks compare the round-robin choice and every ready, back-pressure and data value on each cycle.

// File: rtl/ptrq_pkg.sv
package ptrq_pkg;

  localparam int SCAN_W = 32;

  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
  } pick_t;

  // lowest set bit of a vector of up to SCAN_W bits
  function automatic pick_t pick_lowest(input logic [SCAN_W-1:0] vec);
    pick_t r;
    r = '0;
    for (int k = SCAN_W - 1; k >= 0; k--) begin
      if (vec[k]) begin
        r.hit = 1'b1;
        r.idx = 5'(k);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ptrq_ptr_fifo.sv
module ptrq_ptr_fifo #(
  parameter int DEPTH = 4,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_ptr,
  input  logic          pop,
  output logic [PW-1:0] head_ptr,
  output logic          not_empty,
  output logic          has_room
);
  localparam int DW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [PW-1:0]   ring_q [DEPTH];
  logic [DW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [DW-1:0] bump(input logic [DW-1:0] p);
    return (p == DW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_ptr  = ring_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign has_room  = (cnt_q != CNTW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) ring_q[wr_q] <= push_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> has_room);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
  p_hold_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && !pop) |=> (not_empty && $stable(head_ptr)));

endmodule

// File: rtl/ptrq_in_arb.sv
module ptrq_in_arb #(
  parameter int NIN  = 4,
  parameter int NOUT = 4,
  parameter int IW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       req_valid,
  input  logic [NIN*NOUT-1:0]  req_mask,
  input  logic [NIN-1:0]       has_addr,
  input  logic [NOUT-1:0]      q_room,
  output logic [NIN-1:0]       grant,
  output logic                 grant_any,
  output logic [IW-1:0]        grant_idx,
  output logic [NIN-1:0]       refuse
);
  logic [NIN-1:0] elig;
  logic [IW-1:0]  rr_q;

  for (genvar i = 0; i < NIN; i++) begin : g_elig
    logic [NOUT-1:0] m;
    assign m       = req_mask[i*NOUT +: NOUT];
    assign elig[i] = req_valid[i] & has_addr[i] & (|m) & ((m & ~q_room) == '0);
  end

  always_comb begin
    logic [IW-1:0] c;
    grant     = '0;
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 0; k < NIN; k++) begin
      c = IW'((int'(rr_q) + k) % NIN);
      if (!grant_any && elig[c]) begin
        grant_any = 1'b1;
        grant_idx = c;
        grant[c]  = 1'b1;
      end
    end
  end

  assign refuse = req_valid & ~elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (grant_any)
      rr_q <= (grant_idx == IW'(NIN - 1)) ? '0 : grant_idx + 1'b1;
  end

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_needs_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~(req_valid & has_addr)) == '0));
  p_refuse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & refuse) == '0));

endmodule

// File: rtl/ptrq_free_pool.sv
module ptrq_free_pool
  import ptrq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int NIN   = 4,
  parameter int NOUT  = 4,
  parameter int AW    = 3,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NIN-1:0]      need,
  input  logic                acc_valid,
  input  logic [AW-1:0]       acc_addr,
  input  logic [CW-1:0]       acc_refs,
  input  logic [NOUT-1:0]     pop,
  input  logic [NOUT*AW-1:0]  pop_addr,
  output logic                give_valid,
  output logic [IW-1:0]       give_idx,
  output logic [AW-1:0]       give_addr
);
  logic [SLOTS-1:0] free_v;
  logic [CW-1:0]    cnt_v [SLOTS];
  pick_t            pk_in, pk_slot;

  assign pk_in      = pick_lowest(SCAN_W'(need));
  assign pk_slot    = pick_lowest(SCAN_W'(free_v));
  assign give_valid = pk_in.hit & pk_slot.hit;
  assign give_idx   = IW'(pk_in.idx);
  assign give_addr  = AW'(pk_slot.idx);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CW-1:0] dec;
    logic          rel;
    logic [CW-1:0] cnt_q;
    logic          free_q;

    always_comb begin
      dec = '0;
      for (int k = 0; k < NOUT; k++)
        if (pop[k] && pop_addr[k*AW +: AW] == AW'(s)) dec = dec + 1'b1;
    end

    assign rel       = (dec != '0) && (cnt_q == dec);
    assign free_v[s] = free_q;
    assign cnt_v[s]  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        free_q <= 1'b1;
      end else begin
        if (acc_valid && acc_addr == AW'(s)) cnt_q <= acc_refs;
        else                                 cnt_q <= cnt_q - dec;
        if (give_valid && give_addr == AW'(s)) free_q <= 1'b0;
        else if (rel)                          free_q <= 1'b1;
      end
    end
  end

  p_alloc_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    give_valid |-> free_v[give_addr]);
  p_acc_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (!free_v[acc_addr] && cnt_v[acc_addr] == '0));

  for (genvar k = 0; k < NOUT; k++) begin : g_chk
    p_pop_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop[k] |-> (cnt_v[pop_addr[k*AW +: AW]] != '0 && !free_v[pop_addr[k*AW +: AW]]));
  end

endmodule

// File: rtl/ptrq_switch.sv
module ptrq_switch #(
  parameter int NPORT     = 4,
  parameter int WORD_W    = 16,
  parameter int PKT_WORDS = 4,
  parameter int SLOTS     = 8,
  parameter int QDEPTH    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPORT-1:0]                  in_valid,
  input  logic [NPORT*NPORT-1:0]            in_dest,
  input  logic [NPORT*WORD_W*PKT_WORDS-1:0] in_data,
  output logic [NPORT-1:0]                  in_ready,
  output logic [NPORT-1:0]                  in_bp,
  output logic [NPORT-1:0]                  out_valid,
  input  logic [NPORT-1:0]                  out_ready,
  output logic [NPORT*WORD_W*PKT_WORDS-1:0] out_data
);
  localparam int PKT_W = WORD_W * PKT_WORDS;
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CW    = $clog2(NPORT + 1);

  // per-input pre-assigned slot
  logic [NPORT-1:0] held_v_q;
  logic [AW-1:0]    held_addr_q [NPORT];

  logic [NPORT-1:0] grant, refuse, q_room, q_ne, push, pop;
  logic             g_any;
  logic [IW-1:0]    g_idx;
  logic [NPORT-1:0] mask_g;
  logic [PKT_W-1:0] data_g;
  logic [AW-1:0]    addr_g;
  logic [AW-1:0]    head [NPORT];
  logic [NPORT*AW-1:0] pop_addr;
  logic             give_valid;
  logic [IW-1:0]    give_idx;
  logic [AW-1:0]    give_addr;

  logic [PKT_W-1:0] store_q [SLOTS];

  ptrq_in_arb #(.NIN(NPORT), .NOUT(NPORT), .IW(IW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (in_valid),
    .req_mask  (in_dest),
    .has_addr  (held_v_q),
    .q_room    (q_room),
    .grant     (grant),
    .grant_any (g_any),
    .grant_idx (g_idx),
    .refuse    (refuse)
  );

  assign mask_g = in_dest[g_idx*NPORT +: NPORT];
  assign data_g = in_data[g_idx*PKT_W +: PKT_W];
  assign addr_g = held_addr_q[g_idx];
  assign push   = {NPORT{g_any}} & mask_g;
  assign pop    = q_ne & out_ready;

  assign in_ready  = grant;
  assign in_bp     = refuse;
  assign out_valid = q_ne;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    ptrq_ptr_fifo #(.DEPTH(QDEPTH), .PW(AW)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[o]),
      .push_ptr  (addr_g),
      .pop       (pop[o]),
      .head_ptr  (head[o]),
      .not_empty (q_ne[o]),
      .has_room  (q_room[o])
    );
    assign pop_addr[o*AW +: AW]    = head[o];
    assign out_data[o*PKT_W +: PKT_W] = store_q[head[o]];
  end

  ptrq_free_pool #(
    .SLOTS(SLOTS), .NIN(NPORT), .NOUT(NPORT), .AW(AW), .IW(IW), .CW(CW)
  ) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .need       (~held_v_q),
    .acc_valid  (g_any),
    .acc_addr   (addr_g),
    .acc_refs   (CW'($countones(mask_g))),
    .pop        (pop),
    .pop_addr   (pop_addr),
    .give_valid (give_valid),
    .give_idx   (give_idx),
    .give_addr  (give_addr)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_v_q[i]    <= 1'b0;
        held_addr_q[i] <= '0;
      end else if (g_any && g_idx == IW'(i)) begin
        held_v_q[i] <= 1'b0;
      end else if (give_valid && give_idx == IW'(i)) begin
        held_v_q[i]    <= 1'b1;
        held_addr_q[i] <= give_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (g_any) store_q[addr_g] <= data_g;
  end

  p_one_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
  p_bp_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & in_bp) == '0));
  p_give_unheld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    give_valid |-> !held_v_q[give_idx]);
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[0] && !out_ready[0]) |=> (out_valid[0] && $stable(out_data[PKT_W-1:0])));

endmodule

// File: tb/ptrq_switch_test.sv
module ptrq_switch_test;
  localparam int NP = 4, WW = 16, PWD = 4, SL = 8, QD = 4;
  localparam int PKT_W = WW * PWD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]       d_valid = '0, d_oready = '0;
  logic [NP*NP-1:0]    d_mask = '0;
  logic [NP*PKT_W-1:0] d_data = '0;
  logic [NP-1:0]       in_ready, in_bp, out_valid;
  logic [NP*PKT_W-1:0] out_data;

  ptrq_switch #(.NPORT(NP), .WORD_W(WW), .PKT_WORDS(PWD), .SLOTS(SL), .QDEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid), .in_dest(d_mask), .in_data(d_data),
    .in_ready(in_ready), .in_bp(in_bp), .out_valid(out_valid), .out_ready(d_oready),
    .out_data(out_data)
  );

  int errors = 0, checks = 0, serial = 0;
  bit held [NP];
  int free_cnt, rr;
  logic [PKT_W-1:0] mq [NP][$];
  int refs [logic [PKT_W-1:0]];
  int acc_obs;
  bit last_acc [NP];
  logic [PKT_W-1:0] watch_tag = '1;
  int watch_hits = 0;

  task automatic chk(input bit ok, input string req, input logic [PKT_W-1:0] act,
                     input logic [PKT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PKT_W-1:0] mk(input int i);
    serial++;
    return {16'(i), 16'hC0DE, 32'(serial)};
  endfunction

  // compare one cycle against the model, then advance the model over the edge
  task automatic step();
    int g, rel;
    bit elig [NP];
    bit ev [NP];
    bit done;
    logic [NP-1:0] er, eb, m;
    logic [PKT_W-1:0] p;
    #2;
    for (int i = 0; i < NP; i++) begin
      m = d_mask[i*NP +: NP];
      elig[i] = d_valid[i] && held[i] && (m != '0);
      for (int o = 0; o < NP; o++)
        if (m[o] && mq[o].size() >= QD) elig[i] = 1'b0;
    end
    g = -1;
    for (int k = 0; k < NP; k++)
      if (g < 0 && elig[(rr + k) % NP]) g = (rr + k) % NP;
    er = '0; eb = '0;
    for (int i = 0; i < NP; i++) begin
      er[i] = (i == g);
      eb[i] = d_valid[i] && !elig[i];
    end
    chk(in_ready == er, "R1 R2 R3 in_ready", PKT_W'(in_ready), PKT_W'(er));
    chk(in_bp == eb, "R4 R7 R8 in_bp", PKT_W'(in_bp), PKT_W'(eb));
    for (int o = 0; o < NP; o++) begin
      ev[o] = (mq[o].size() > 0);
      chk(out_valid[o] == ev[o], "R5 out_valid", PKT_W'(out_valid[o]), PKT_W'(ev[o]));
      if (ev[o]) chk(out_data[o*PKT_W +: PKT_W] == mq[o][0], "R5 R6 out_data",
                     out_data[o*PKT_W +: PKT_W], mq[o][0]);
    end
    acc_obs += $countones(in_ready);
    for (int i = 0; i < NP; i++) last_acc[i] = in_ready[i];
    rel = 0;
    for (int o = 0; o < NP; o++) begin
      if (ev[o] && d_oready[o]) begin
        p = mq[o].pop_front();
        if (p == watch_tag) watch_hits++;
        refs[p] = refs[p] - 1;
        if (refs[p] == 0) begin
          rel++;
          refs.delete(p);
        end
      end
    end
    done = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (!done && !held[i] && free_cnt > 0) begin
        held[i] = 1'b1;
        free_cnt--;
        done = 1'b1;
      end
    end
    if (g >= 0) begin
      held[g] = 1'b0;
      p = d_data[g*PKT_W +: PKT_W];
      m = d_mask[g*NP +: NP];
      refs[p] = $countones(m);
      for (int o = 0; o < NP; o++) if (m[o]) mq[o].push_back(p);
      rr = (g + 1) % NP;
    end
    free_cnt += rel;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [NP-1:0] ordy);
    d_valid = '0;
    d_oready = ordy;
    for (int c = 0; c < n; c++) step();
  endtask

  task automatic fill_test(input string tag);
    acc_obs = 0;
    d_oready = '0;
    for (int c = 0; c < 40; c++) begin
      for (int i = 0; i < NP; i++) begin
        d_valid[i] = 1'b1;
        d_mask[i*NP +: NP] = NP'(1 << i);
        d_data[i*PKT_W +: PKT_W] = mk(i);
      end
      step();
    end
    chk(acc_obs == SL, tag, PKT_W'(acc_obs), PKT_W'(SL));
    idle(60, '1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired before the run ended (R1..all)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) held[i] = 1'b0;
    free_cnt = SL;
    rr = 0;
    acc_obs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(out_valid == '0, "R1 reset out_valid", PKT_W'(out_valid), '0);
    chk(in_ready == '0, "R1 reset in_ready", PKT_W'(in_ready), '0);

    // unicast, rotating destinations, all outputs draining
    for (int c = 0; c < 200; c++) begin
      d_oready = '1;
      for (int i = 0; i < NP; i++) begin
        d_valid[i] = 1'b1;
        d_mask[i*NP +: NP] = NP'(1 << ((i + c) % NP));
        d_data[i*PKT_W +: PKT_W] = mk(i);
      end
      step();
    end

    // contention on output 0 with it stalled: queue fills, then R4 back-pressure
    for (int c = 0; c < 30; c++) begin
      d_oready = '0;
      for (int i = 0; i < NP; i++) begin
        d_valid[i] = 1'b1;
        d_mask[i*NP +: NP] = NP'(1);
        d_data[i*PKT_W +: PKT_W] = mk(i);
      end
      step();
    end
    idle(30, '1);

    // R4: zero mask is refused
    d_valid = '0;
    d_valid[1] = 1'b1;
    d_mask = '0;
    d_data[PKT_W +: PKT_W] = mk(1);
    for (int c = 0; c < 5; c++) step();
    idle(20, '1);

    // R6: broadcast from input 0
    watch_tag = mk(0);
    watch_hits = 0;
    d_valid = '0;
    d_valid[0] = 1'b1;
    d_mask[NP-1:0] = '1;
    d_data[PKT_W-1:0] = watch_tag;
    d_oready = '1;
    for (int c = 0; c < 10; c++) begin
      step();
      if (last_acc[0]) break;
    end
    idle(20, '1);
    chk(watch_hits == NP, "R6 broadcast copies delivered", PKT_W'(watch_hits), PKT_W'(NP));

    // random traffic, random stalls
    for (int c = 0; c < 4000; c++) begin
      d_valid = NP'($urandom);
      d_oready = NP'($urandom);
      for (int i = 0; i < NP; i++) begin
        d_mask[i*NP +: NP] = NP'($urandom);
        d_data[i*PKT_W +: PKT_W] = mk(i);
      end
      step();
    end
    idle(60, '1);

    // R7 capacity and no leak, then R8 reuse after release
    fill_test("R7 accepted with outputs stalled");
    fill_test("R8 accepted after slots released");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule